// File: doc/BRIEF.md
# General-Purpose I/O Port Bank

This block holds an 8-pin general-purpose I/O bank for a small microcontroller. Each pin has two stored bits: a direction bit and a data bit. The pair selects one of four pad behaviours: driven high, driven low, input with pull-up, or high-impedance. A single global pull-up-kill input comes from a system control register. When it is set, the pull-up of every input pin is turned off at once.

Software reaches the bank over a simple register bus with three addresses. Two addresses hold the direction and data registers, which read back their stored values. The third address is the pin-sense register. A read returns the synchronized pad levels. A write of ones inverts the matching data bits and does not store anything.

Pad levels enter through a level-sensitive latch followed by a flop. The latch is open while the clock is low. The flop captures the latch on the rising edge. This pair guards against metastability.

Top module: `gpio_bank`

## Requirements
- R1: While rstN is low and after its release, direction and data are all zero. Every pad then has padOe=0, padOut=0 and padPullEn=0.
- R2: A pin whose direction bit is 1 has padOe=1 and padOut equal to its data bit. Its padPullEn is 0.
- R3: A pin whose direction bit is 0 and whose data bit is 1 has padPullEn=1 only while pullupOff is 0. While pullupOff is 1, padPullEn is 0 on all pins.
- R4: A pin whose direction and data bits are both 0 has padOe=0, padOut=0 and padPullEn=0.
- R5: A write to address 0 inverts each data bit whose write-data bit is 1, whatever the direction. Data bits whose write-data bit is 0 keep their value. The direction register is unchanged.
- R6: A write to address 1 loads the direction register and a write to address 2 loads the data register, both on the rising clock edge. Reads of address 1 and address 2 return the stored values.
- R7: A read of address 0 returns the pad levels captured at the most recent rising edge, whatever the direction setting. Pad changes made while the clock is high are not captured until the following rising edge, because the latch is closed during the high phase.
- R8: A write to address 3 changes no register, and a read of address 3 returns zero.
- R9: At most one of the three register-update strobes (direction load, data load, data invert) is active in any cycle. An invert and a plain data load therefore never coincide.
- R10: Each register write changes the pad encoding of a pin in one step. Going from input-with-pull-up to output low through an invert write and then a direction write gives the sequence pull-up, high-impedance, drive-low. A direction write alone gives pull-up, then drive-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the input latch is open while it is low |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 pin sense, 1 direction, 2 data |
| busWrEn | input | 1 | Write strobe, acted on at the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| pullupOff | input | 1 | Global pull-up disable |
| padIn | input | 8 | Pad input levels, asynchronous |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin driven level |
| padPullEn | output | 8 | Per-pin pull-up enable |

## Verification
The hardest behaviour to reach from the ports is the closed phase of the input latch. A pad pulse that lies entirely inside the clock-high phase must leave no trace in the pin-sense register. The stimulus produces this by driving a glitch shortly after a rising edge and restoring the pad before the falling edge, then reading address 0. A second hard case is the order of the transition states. The pad encoding of one pin is recorded after each write in the pull-up-to-output sequences, and the record is compared with the expected order.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PIN  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  typedef enum logic [1:0] {
    RD_PIN  = 2'd0,
    RD_DIR  = 2'd1,
    RD_DATA = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrData;
    logic   flipData;
    rdSel_e rdSel;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output gpioStrobe_t       strobe
);
  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    unique case (busAddr)
      ADDR_PIN: begin
        strobe.flipData = busWrEn;
        strobe.rdSel    = RD_PIN;
      end
      ADDR_DIR: begin
        strobe.wrDir = busWrEn;
        strobe.rdSel = RD_DIR;
      end
      ADDR_DATA: begin
        strobe.wrData = busWrEn;
        strobe.rdSel  = RD_DATA;
      end
      default: begin
        strobe.rdSel = RD_NONE;
      end
    endcase
  end

  // R9: invert and plain load are mutually exclusive
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDir, strobe.wrData, strobe.flipData}));

  // R8: unused address never raises a strobe
  assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> !(strobe.wrDir || strobe.wrData || strobe.flipData));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic                 pullupOff,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullEn
);
  localparam int PW = PIN_COUNT;

  logic [PW-1:0] dirReg;
  logic [PW-1:0] dataReg;
  logic [PW-1:0] latchQ;
  logic [PW-1:0] pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
    end else if (strobe.wrDir) begin
      dirReg <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.wrData) begin
      dataReg <= busWrData;
    end else if (strobe.flipData) begin
      dataReg <= dataReg ^ busWrData;
    end
  end

  // input synchronizer: open while clock low, then flop on rising edge
  always_latch begin
    if (!clk) latchQ = padIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= '0;
    else       pinSync <= latchQ;
  end

  // per-pin pad control encoding
  for (genvar p = 0; p < PW; p++) begin : gPad
    always_comb begin
      padOe[p]     = dirReg[p];
      padOut[p]    = dirReg[p] & dataReg[p];
      padPullEn[p] = ~dirReg[p] & dataReg[p] & ~pullupOff;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_PIN:  busRdData = pinSync;
      RD_DIR:  busRdData = dirReg;
      RD_DATA: busRdData = dataReg;
      default: busRdData = '0;
    endcase
  end

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flipData |=> dataReg == $past(dataReg ^ busWrData));

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirReg));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrData || strobe.flipData) |=> $stable(dataReg));

  assert_pull_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    pullupOff |-> padPullEn == '0);

  assert_no_pull_on_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullEn) == '0);

  assert_sync_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> pinSync == $past(latchQ));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic                 pullupOff,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullEn
);
  gpioStrobe_t strobe;

  gpio_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pullupOff (pullupOff),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullEn (padPullEn)
  );
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       pullupOff = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mDir = '0, mData = '0, mPin = '0;
  logic       pofV = 1'b0;
  logic [2:0] seqLog[$];

  always #(CLK_P/2) clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pullupOff(pullupOff),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [7:0] expRd;
    string rdTag;
    chk(rstN ? "R2 padOe" : "R1 padOe", padOe, mDir);
    chk(rstN ? "R2 padOut" : "R1 padOut", padOut, mDir & mData);
    chk(rstN ? "R3/R4 padPullEn" : "R1 padPullEn", padPullEn, ~mDir & mData & {8{~pofV}});
    case (busAddr)
      2'd0: begin expRd = mPin;  rdTag = "R7 pin read"; end
      2'd1: begin expRd = mDir;  rdTag = "R6 dir read"; end
      2'd2: begin expRd = mData; rdTag = "R6 data read"; end
      default: begin expRd = '0; rdTag = "R8 unused read"; end
    endcase
    chk(rdTag, busRdData, expRd);
  endtask

  task automatic cyc(input logic [1:0] a, input logic we, input logic [7:0] wd,
                     input logic [7:0] pad, input bit glitch = 0);
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = wd; padIn = pad; pullupOff = pofV;
    @(posedge clk);
    if (!rstN) begin
      mDir = '0; mData = '0; mPin = '0;
    end else begin
      if (we && a == 2'd1) mDir = wd;
      if (we && a == 2'd2) mData = wd;
      if (we && a == 2'd0) mData = mData ^ wd;
      mPin = pad;
    end
    if (glitch) begin
      #1 padIn = ~pad;
      #1 padIn = pad;
    end
    #(CLK_P/4);
    compareAll();
  endtask

  function automatic logic [2:0] enc0();
    return {padOe[0], padOut[0], padPullEn[0]};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (3) cyc(2'd0, 1'b0, 8'h00, 8'h3C);
    rstN = 1'b1;
    cyc(2'd1, 1'b0, 8'h00, 8'h3C);
    // R6: loads and readback
    cyc(2'd1, 1'b1, 8'hF0, 8'h00);
    cyc(2'd2, 1'b1, 8'hA5, 8'h00);
    cyc(2'd1, 1'b0, 8'h00, 8'h00);
    cyc(2'd2, 1'b0, 8'h00, 8'h00);
    // R3: global pull-up kill
    pofV = 1'b1;
    cyc(2'd2, 1'b0, 8'h00, 8'h00);
    pofV = 1'b0;
    cyc(2'd2, 1'b0, 8'h00, 8'h00);
    // R5: invert across inputs and outputs, zero write leaves data
    cyc(2'd0, 1'b1, 8'h3C, 8'h00);
    cyc(2'd0, 1'b1, 8'h00, 8'h00);
    cyc(2'd2, 1'b0, 8'h00, 8'h00);
    // R8: unused address
    cyc(2'd3, 1'b1, 8'hFF, 8'h00);
    cyc(2'd3, 1'b0, 8'h00, 8'h00);
    // R7: pad sensing, independent of direction
    cyc(2'd0, 1'b0, 8'h00, 8'h5A);
    cyc(2'd0, 1'b0, 8'h00, 8'hC3);
    cyc(2'd1, 1'b1, 8'h0F, 8'h81);
    cyc(2'd0, 1'b0, 8'h00, 8'h7E);
    // R7: glitch inside high phase must not be captured
    cyc(2'd0, 1'b0, 8'h00, 8'h24, 1);
    cyc(2'd0, 1'b0, 8'h00, 8'h24);
    // R4: tri-state everywhere
    cyc(2'd1, 1'b1, 8'h00, 8'h00);
    cyc(2'd2, 1'b1, 8'h00, 8'h00);
    // R10: pull-up -> tri-state -> drive low
    cyc(2'd2, 1'b1, 8'h01, 8'h00); seqLog.push_back(enc0());
    cyc(2'd0, 1'b1, 8'h01, 8'h00); seqLog.push_back(enc0());
    cyc(2'd1, 1'b1, 8'h01, 8'h00); seqLog.push_back(enc0());
    // R10: pull-up -> drive high
    cyc(2'd1, 1'b1, 8'h00, 8'h00);
    cyc(2'd2, 1'b1, 8'h01, 8'h00); seqLog.push_back(enc0());
    cyc(2'd1, 1'b1, 8'h01, 8'h00); seqLog.push_back(enc0());
    chk("R10 seq len", 8'(seqLog.size()), 8'd5);
    if (seqLog.size() == 5) begin
      chk("R10 step0 pull-up", {5'd0, seqLog[0]}, 8'b001);
      chk("R10 step1 hi-z",    {5'd0, seqLog[1]}, 8'b000);
      chk("R10 step2 low",     {5'd0, seqLog[2]}, 8'b100);
      chk("R10 step3 pull-up", {5'd0, seqLog[3]}, 8'b001);
      chk("R10 step4 high",    {5'd0, seqLog[4]}, 8'b110);
    end
    // R9: each address yields one update; alternate quickly
    for (int i = 0; i < 6; i++) begin
      cyc(2'(i % 3), 1'b1, 8'(8'h11 * i), 8'(i));
    end
    finish();
  end
endmodule